// File: doc/BRIEF.md
# Generator-Store Block Marshal Buffer

This block sits beside one core's store path. It notes the cache-block address of every committed store that the compiler tagged as a generator. A generator store is the last write to a block that the next code segment will consume. Addresses are kept at 64-byte block granularity, and a block is kept only once. When software issues a marshal command that names a destination core, the block sends every noted block address out on a valid/ready push stream, tagged with that core. The cache and interconnect then move the data ahead of the consumer.

The storage is a small ordered list of 16 block addresses. A marshal command drains it oldest first, one entry per accepted handshake. It ends empty. While it drains, the store and command ports hold off by dropping their ready signals. A generator block that arrives when the list is full is discarded and counted. Pushing a block that is not needed is harmless, so losing or duplicating hints never affects correctness.

Top module: `marshal_addr_buf`

## Requirements
- R1: After reset, st_ready and mc_ready are 1, push_valid is 0 and drop_count is 0.
- R2: An accepted store with st_gen=1 records its block address st_addr[47:6]. That value later appears on push_blk.
- R3: An accepted store with st_gen=0 records nothing and never appears on the push stream.
- R4: A generator store to a block that is already held, at any byte offset within the block, adds no second entry.
- R5: At most 16 blocks are held. A generator store to a new block while 16 are held is discarded, and drop_count rises by one, saturating at all ones. A repeated block while full does not count.
- R6: An accepted marshal command pushes every held block with push_core equal to its mc_core, oldest recorded first. push_valid rises in the cycle after the command is accepted.
- R7: One entry leaves per cycle in which push_valid and push_ready are both 1. While push_ready is 0, push_valid, push_blk and push_core hold their values.
- R8: While entries remain to push, st_ready and mc_ready are 0. Both return to 1 in the cycle after the last push is accepted, and the list is then empty.
- R9: A marshal command accepted with nothing held produces no push and leaves both ready signals at 1.
- R10: A generator store accepted in the same cycle as a marshal command is recorded first and pushed as the last entry of that drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Committed store present |
| st_ready | output | 1 | Store port can accept (low while draining) |
| st_gen | input | 1 | Store carries the generator tag |
| st_addr | input | 48 | Store physical byte address |
| mc_valid | input | 1 | Marshal command present |
| mc_ready | output | 1 | Command port can accept (low while draining) |
| mc_core | input | 6 | Destination core of the marshal command |
| push_valid | output | 1 | Push request present |
| push_ready | input | 1 | Push request taken |
| push_blk | output | 42 | Block address to push |
| push_core | output | 6 | Destination core of the push |
| drop_count | output | 16 | Saturating count of discarded generator blocks |

## Verification
Some properties are checked every cycle by the assertions. The held count never passes 16. A stalled push keeps its address and destination. The destination stays fixed through a drain. The drop counter moves only on a generator store that meets a full list. The list is empty whenever a drain ends. Other behaviours only the bench scenarios can show. These are the exact push order, removal of duplicates across byte offsets, the filtering of untagged stores, a marshal of an empty list, and a store that arrives in the same cycle as a command. The bench shows them by comparing the push stream against a queue model under random tags, addresses and back-pressure.

// File: rtl/marshal_addr_buf.sv
module marshal_addr_buf #(
  parameter int PADDR_W   = 48,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 16,
  parameter int CORE_W    = 6,
  parameter int DROP_W    = 16,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = PADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic              st_gen,
  input  logic [PADDR_W-1:0] st_addr,
  input  logic              mc_valid,
  output logic              mc_ready,
  input  logic [CORE_W-1:0] mc_core,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BLK_W-1:0]  push_blk,
  output logic [CORE_W-1:0] push_core,
  output logic [DROP_W-1:0] drop_count
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [BLK_W-1:0]  ent [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic              busy;
  logic [CORE_W-1:0] dest;
  logic              hit;

  wire st_fire = st_valid & st_ready;
  wire mc_fire = mc_valid & mc_ready;
  wire pop     = push_valid & push_ready;
  wire full    = (cnt == CNT_W'(DEPTH));
  wire [BLK_W-1:0] st_blk = st_addr[PADDR_W-1:OFF_W];
  wire rec = st_fire & st_gen & ~hit & ~full;
  wire drp = st_fire & st_gen & ~hit & full;

  assign st_ready   = ~busy;
  assign mc_ready   = ~busy;
  assign push_valid = busy;
  assign push_blk   = ent[0];
  assign push_core  = dest;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i) < cnt && ent[i] == st_blk) hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      busy       <= 1'b0;
      dest       <= '0;
      drop_count <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      if (rec) begin
        ent[cnt[IDX_W-1:0]] <= st_blk;
        cnt <= cnt + 1'b1;
      end
      if (drp && drop_count != '1) drop_count <= drop_count + 1'b1;
      if (mc_fire) begin
        dest <= mc_core;
        busy <= (cnt != '0) || rec;
      end
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_drop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_fire && st_gen && full) |=> $stable(drop_count));

  assert_push_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_blk) && $stable(push_core));

  assert_dest_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && $past(push_valid) |-> $stable(push_core));

  assert_empty_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt == '0);
endmodule

// File: tb/tb_marshal_addr_buf.sv
module tb_marshal_addr_buf;
  localparam int DW = 4;
  localparam int BW = 42;

  logic clk = 0, rst_n = 0;
  logic st_valid = 0, st_gen = 0, mc_valid = 0, push_ready = 0;
  logic [47:0] st_addr = '0;
  logic [5:0]  mc_core = '0;
  logic st_ready, mc_ready, push_valid;
  logic [BW-1:0] push_blk;
  logic [5:0] push_core;
  logic [DW-1:0] drop_count;

  marshal_addr_buf #(.DROP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_gen(st_gen),
    .st_addr(st_addr), .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_core(mc_core),
    .push_valid(push_valid), .push_ready(push_ready), .push_blk(push_blk),
    .push_core(push_core), .drop_count(drop_count));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [BW-1:0] mq[$];
  int mdrop = 0;
  logic [5:0] mdest;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk_addr(input logic [BW-1:0] blk, input logic [5:0] off);
    return {blk, off};
  endfunction

  task automatic model_store(input bit gen, input logic [47:0] a);
    logic [BW-1:0] b = a[47:6];
    bit found = 0;
    if (!gen) return;
    foreach (mq[i]) if (mq[i] == b) found = 1;
    if (found) return;
    if (mq.size() < 16) mq.push_back(b);
    else if (mdrop < (1 << DW) - 1) mdrop++;
  endtask

  task automatic store(input bit gen, input logic [47:0] a);
    @(negedge clk);
    st_valid = 1; st_gen = gen; st_addr = a;
    @(posedge clk);
    model_store(gen, a);
    #1 st_valid = 0; st_gen = 0;
  endtask

  task automatic marshal(input logic [5:0] core, input int pct, input bit with_st, input logic [47:0] a);
    logic [BW-1:0] pb;
    logic [5:0] pc;
    bit stalled = 0;
    @(negedge clk);
    mc_valid = 1; mc_core = core;
    if (with_st) begin st_valid = 1; st_gen = 1; st_addr = a; end
    @(posedge clk);
    if (with_st) model_store(1, a);
    mdest = core;
    #1 mc_valid = 0; st_valid = 0; st_gen = 0;
    forever begin
      @(negedge clk);
      if (mq.size() == 0) begin
        chk(!push_valid, "R8 R9 push_valid after drain", 64'(push_valid), 0);
        chk(st_ready && mc_ready, "R8 ready after drain", {st_ready, mc_ready}, 2'b11);
        break;
      end
      chk(push_valid, "R6 push_valid", 64'(push_valid), 1);
      chk(!st_ready && !mc_ready, "R8 ready low while draining", {st_ready, mc_ready}, 0);
      chk(push_blk == mq[0], "R2 R6 push_blk order", 64'(push_blk), 64'(mq[0]));
      chk(push_core == mdest, "R6 push_core", 64'(push_core), 64'(mdest));
      if (stalled)
        chk(push_blk == pb && push_core == pc, "R7 hold while stalled", 64'(push_blk), 64'(pb));
      pb = push_blk; pc = push_core;
      push_ready = ($urandom_range(99) < pct);
      stalled = !push_ready;
      @(posedge clk);
      if (push_ready) void'(mq.pop_front());
      #1 push_ready = 0;
    end
  endtask

  task automatic chk_drop(input string req);
    @(negedge clk);
    chk(drop_count == DW'(mdrop), req, 64'(drop_count), 64'(mdrop));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] base = 42'h0_1234_5600;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(st_ready && mc_ready, "R1 ready at reset", {st_ready, mc_ready}, 2'b11);
    chk(!push_valid, "R1 push_valid at reset", 64'(push_valid), 0);
    chk(drop_count == 0, "R1 drop_count at reset", 64'(drop_count), 0);

    // R2 R3 R4 directed
    store(1, mk_addr(base, 6'h10));
    store(1, mk_addr(base, 6'h3F));
    store(0, mk_addr(base + 1, 6'h00));
    store(1, mk_addr(base + 2, 6'h08));
    chk(mq.size() == 2, "R3 R4 model entries", mq.size(), 2);
    marshal(6'd5, 100, 0, '0);

    // R9 empty marshal
    marshal(6'd3, 100, 0, '0);

    // R5 fill, drop, duplicate while full
    for (int i = 0; i < 16; i++) store(1, mk_addr(base + 42'(i * 3), 6'(i)));
    chk_drop("R5 no drop below capacity");
    for (int i = 0; i < 3; i++) store(1, mk_addr(base + 42'(100 + i), 6'h0));
    store(1, mk_addr(base + 42'(9), 6'h20));
    chk_drop("R5 drops counted, duplicate ignored");
    marshal(6'd17, 40, 0, '0);

    // R5 saturation
    for (int i = 0; i < 36; i++) store(1, mk_addr(base + 42'(200 + i), 6'h1));
    chk_drop("R5 saturating drop count");
    chk(drop_count == DW'((1 << DW) - 1), "R5 saturated value", 64'(drop_count), (1 << DW) - 1);
    marshal(6'd63, 70, 0, '0);

    // R10 store with marshal
    store(1, mk_addr(base + 42'(500), 6'h2));
    marshal(6'd9, 100, 1, mk_addr(base + 42'(501), 6'h4));

    // random mix
    for (int r = 0; r < 40; r++) begin
      int n = $urandom_range(25);
      for (int k = 0; k < n; k++) begin
        int p = $urandom_range(23);
        store($urandom_range(99) < 75, mk_addr(base + 42'(1000 + p * 55), 6'($urandom_range(63))));
      end
      chk_drop("R5 random drop count");
      marshal(6'($urandom_range(63)), 50, $urandom_range(3) == 0,
              mk_addr(base + 42'(3000 + r), 6'h0));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule